// File: doc/BRIEF.md
# System Clock Divider Controller

This block turns a base clock into a bus-master clock-enable strobe. The strobe runs either at the full base rate or at one of five divided medium-speed rates. Software picks the rate through a clock-control register on a small register bus. A free-running counter makes the divided strobes, and a new rate is adopted only at a pulse boundary of the current rate, so no divided period is ever cut short.

A second register, the low-power control register, holds a pending PLL multiplication factor. The factor that is actually in force is driven on `mult_act`. A commit-mode bit chooses when a newly written factor reaches `mult_act`: at once, or only when one of the three low-power entry strobes (software standby, watch, subactive) arrives. Power-on reset and hardware standby clear the low-power register. Entering software standby leaves it as it is.

Top module: `sysclk_divctl`

## Requirements
- R1: After power-on reset, address 0 and address 1 both read 0x00, `mult_act` is 0, and `clk_en` is high on every cycle (full speed).
- R2: Select codes 1 to 5 in clock-control bits 2:0 give one single-cycle `clk_en` pulse every 2, 4, 8, 16 and 32 base cycles. Code 0 keeps `clk_en` high on every cycle.
- R3: A clock-control write whose select code is 6 or 7 leaves the select field and the division ratio unchanged. Bit 3 of that write is still stored.
- R4: A new select code takes effect only at the next `clk_en` pulse of the ratio currently in force.
- R5: Reading address 0 returns {4'b0, commit bit, select}. Reading address 1 returns bits 7:3 as written, bit 2 as 0, and the pending factor in bits 1:0.
- R6: With commit bit 3 of address 0 at 0, a write of the factor leaves `mult_act` unchanged. The cycle after a software-standby, watch or subactive entry strobe, `mult_act` shows the pending factor.
- R7: With the commit bit at 1, `mult_act` shows the written factor on the cycle after the address 1 write.
- R8: A software-standby entry strobe does not change the contents of address 1.
- R9: `hw_stby` clears address 1 and `mult_act` to 0 and leaves the clock-control register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| hw_stby | input | 1 | Hardware standby, synchronous clear of the low-power register |
| sw_stby_ent | input | 1 | Software-standby entry strobe |
| watch_ent | input | 1 | Watch-mode entry strobe |
| subact_ent | input | 1 | Subactive-mode entry strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = clock-control register, 1 = low-power register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| clk_en | output | 1 | Bus-master clock-enable strobe |
| mult_act | output | 2 | Multiplication factor in force |

## Verification
The bench writes a slow ratio and then a fast one just after a pulse. A design that switched at once would emit extra pulses inside the 32-cycle period that is still running. It writes reserved select codes, which would otherwise select an undefined ratio and change the pulse count. In deferred mode it checks that `mult_act` stays put after a factor write, and that each of the three entry strobes commits the factor. A design that committed on the write, or missed one of the strobes, would show the wrong factor. The bench also confirms that software standby keeps the low-power register while hardware standby clears it and spares the clock-control register.

// File: rtl/sysclk_divctl.sv
module sysclk_divctl #(
  parameter int DW     = 8,
  parameter int SELW   = 3,
  parameter int MAXSEL = 5,
  parameter int MW     = 2
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          hw_stby,
  input  logic          sw_stby_ent,
  input  logic          watch_ent,
  input  logic          subact_ent,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          clk_en,
  output logic [MW-1:0] mult_act
);
  localparam int CW = MAXSEL;

  logic [CW-1:0]   cnt;
  logic [CW-1:0]   mask;
  logic [SELW-1:0] sel_q, sel_act;
  logic            imm_q;
  logic [DW-1:3]   lp_hi;
  logic [MW-1:0]   pend_q;

  wire wr_ck  = wr_en && !addr;
  wire wr_lp  = wr_en && addr;
  wire entry  = sw_stby_ent || watch_ent || subact_ent;
  wire sel_ok = int'(wdata[SELW-1:0]) <= MAXSEL;

  assign mask   = ~({CW{1'b1}} << sel_act);
  assign clk_en = (cnt & mask) == mask;
  assign rdata  = addr ? {lp_hi, 1'b0, pend_q}
                       : {{(DW-SELW-1){1'b0}}, imm_q, sel_q};

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      cnt     <= '0;
      sel_act <= '0;
      sel_q   <= '0;
      imm_q   <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (clk_en) sel_act <= sel_q;
      if (wr_ck) begin
        imm_q <= wdata[SELW];
        if (sel_ok) sel_q <= wdata[SELW-1:0];
      end
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      lp_hi    <= '0;
      pend_q   <= '0;
      mult_act <= '0;
    end else if (hw_stby) begin
      lp_hi    <= '0;
      pend_q   <= '0;
      mult_act <= '0;
    end else begin
      if (wr_lp) begin
        lp_hi  <= wdata[DW-1:3];
        pend_q <= wdata[MW-1:0];
      end
      if (wr_lp && imm_q) mult_act <= wdata[MW-1:0];
      else if (entry)     mult_act <= pend_q;
    end

  a_r4_switch_on_pulse: assert property (@(posedge clk) disable iff (!por_n)
    (sel_act != $past(sel_act)) |-> $past(clk_en));
  a_r3_select_legal: assert property (@(posedge clk) disable iff (!por_n)
    int'(sel_q) <= MAXSEL && int'(sel_act) <= MAXSEL);
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!por_n)
    (clk_en && sel_act != 0 && sel_q != 0) |=> !clk_en);
  a_r6_factor_hold: assert property (@(posedge clk) disable iff (!por_n)
    (!hw_stby && !entry && !(wr_lp && imm_q)) |=> $stable(mult_act));
  a_r7_immediate: assert property (@(posedge clk) disable iff (!por_n)
    (wr_lp && imm_q && !hw_stby) |=> mult_act == $past(wdata[MW-1:0]));
  a_r9_hw_clear: assert property (@(posedge clk) disable iff (!por_n)
    hw_stby |=> (mult_act == '0 && pend_q == '0 && lp_hi == '0));
endmodule

// File: tb/test_sysclk_divctl.sv
module test_sysclk_divctl;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       hw_stby = 1'b0, sw_stby_ent = 1'b0, watch_ent = 1'b0, subact_ent = 1'b0;
  logic       wr_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       clk_en;
  logic [1:0] mult_act;
  int tests = 0, fails = 0;
  bit done = 0;

  sysclk_divctl i_sysclk_divctl (
    .clk(clk), .por_n(por_n), .hw_stby(hw_stby), .sw_stby_ent(sw_stby_ent),
    .watch_ent(watch_ent), .subact_ent(subact_ent), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .clk_en(clk_en), .mult_act(mult_act));

  always #5 clk = ~clk;

  localparam logic [10:0] VEC [6] = '{
    {3'd0, 8'd64}, {3'd1, 8'd32}, {3'd2, 8'd16},
    {3'd3, 8'd8},  {3'd4, 8'd4},  {3'd5, 8'd2}};

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic count(int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clk_en) c++;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int c;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    chk("R1 clk_en", clk_en, 1);
    rd(1'b0, d); chk("R1 ctrl", d, 0);
    rd(1'b1, d); chk("R1 lp", d, 0);
    chk("R1 mult_act", mult_act, 0);

    for (int v = 0; v < 6; v++) begin
      wr(1'b0, {5'b0, VEC[v][10:8]});
      repeat (40) @(negedge clk);
      count(64, c);
      chk($sformatf("R2 code %0d pulses", VEC[v][10:8]), c, VEC[v][7:0]);
    end

    wr(1'b0, 8'h02);
    repeat (40) @(negedge clk);
    wr(1'b0, 8'h0E);
    rd(1'b0, d); chk("R3 reserved 6 readback", d, 8'h0A);
    repeat (40) @(negedge clk);
    count(64, c); chk("R3 ratio kept", c, 16);
    wr(1'b0, 8'h07);
    rd(1'b0, d); chk("R3 reserved 7 readback", d, 8'h02);

    wr(1'b0, 8'h05);
    repeat (40) @(negedge clk);
    while (!clk_en) @(negedge clk);
    wr_en = 1'b1; addr = 1'b0; wdata = 8'h01;
    @(negedge clk); wr_en = 1'b0;
    c = clk_en ? 1 : 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (clk_en) c++;
    end
    chk("R4 no early pulse", c, 0);
    @(negedge clk); chk("R4 boundary pulse", clk_en, 1);
    count(32, c); chk("R4 new ratio", c, 16);

    wr(1'b0, 8'h00);
    wr(1'b1, 8'hFF);
    rd(1'b1, d); chk("R5 lp readback", d, 8'hFB);
    chk("R6 no commit on write", mult_act, 0);
    @(negedge clk); sw_stby_ent = 1'b1; @(negedge clk); sw_stby_ent = 1'b0;
    chk("R6 sw standby commit", mult_act, 3);
    rd(1'b1, d); chk("R8 lp kept", d, 8'hFB);
    wr(1'b1, 8'h01);
    chk("R6 hold", mult_act, 3);
    @(negedge clk); watch_ent = 1'b1; @(negedge clk); watch_ent = 1'b0;
    chk("R6 watch commit", mult_act, 1);
    wr(1'b1, 8'h02);
    @(negedge clk); subact_ent = 1'b1; @(negedge clk); subact_ent = 1'b0;
    chk("R6 subactive commit", mult_act, 2);

    wr(1'b0, 8'h0A);
    rd(1'b0, d); chk("R5 ctrl readback", d, 8'h0A);
    wr(1'b1, 8'h01);
    chk("R7 immediate", mult_act, 1);
    wr(1'b1, 8'h03);
    chk("R7 immediate 2", mult_act, 3);

    @(negedge clk); hw_stby = 1'b1; @(negedge clk); hw_stby = 1'b0;
    rd(1'b1, d); chk("R9 lp cleared", d, 0);
    chk("R9 mult cleared", mult_act, 0);
    rd(1'b0, d); chk("R9 ctrl kept", d, 8'h0A);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule